// File: doc/BRIEF.md
# Multi-Phase Ring Oscillator Edge Counter

This block turns the running frequency of a free-running ring oscillator into a digital code measured over a window of system-clock cycles. Software or a sequencer supplies a window length and a one-cycle start pulse. The code reports how far the ring advanced during the window, so it stands for the average oscillator frequency over that interval. Cycle-to-cycle jitter averages out in the count, so no per-edge filtering is applied.

A counter clocked by the first ring tap tracks whole oscillator periods. It counts in Gray code so that the system-clock domain can sample it safely. The system clock also samples all ring taps through synchronizers. Each sample is decoded as a position inside one oscillator period, which has 2×N_STAGES positions. Positions taken at both window edges give a resolution of one stage delay without a counter per stage. One code step equals a voltage step of 1/(oscillator gain × window time). For example, 2.6 GHz/V over a 1 µs window gives about 385 µV. The random oscillator phase at window start adds up to one step of dither, which is left in the code.

Top module: `ring_phase_counter`

## Requirements
- R1: While reset is low, and after it until the first result, conv_busy, conv_done, conv_code and conv_phase_err are all zero.
- R2: A start pulse seen in idle with a nonzero window W is accepted. conv_busy is high for the W+1 cycles after the accepting edge. conv_done pulses in the cycle after that, when conv_busy is already low.
- R3: The code equals ((Ce − Cs) mod 2^CNT_W) × 2·N_STAGES + Pe − Ps. Cs and Ce are rising-edge counts of tap 0, and Ps and Pe are ring positions. All four are taken from the tap values two system edges before the accepting edge, and two system edges before the edge W cycles later.
- R4: Position encoding: invert the odd-indexed taps to get a vector u. For u[0]=1 with k low ones and the rest zeros, the position is k−1. For u[0]=0 with k ones all at the top, the position is 2·N_STAGES−1−k. Position 0 is the state just after tap 0 rises.
- R5: A window during which the coarse counter wraps past its maximum still gives the code of R3.
- R6: A start pulse while conv_busy is high is ignored. The running conversion keeps its timing and result.
- R7: A start pulse with a window length of zero is ignored. conv_busy stays low, no conv_done follows and conv_code is unchanged.
- R8: conv_phase_err is updated with each result. It is 1 when either snapshot is not a pattern of R4, and 0 otherwise. The code is not defined when it is 1.
- R9: conv_code and conv_phase_err hold their values between results.
- R10: conv_done is high for exactly one cycle per conversion.
- R11: The window length is taken at acceptance. Changing conv_window during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset. The ring-domain counter also samples it. |
| conv_start | input | 1 | Start request, one cycle |
| conv_window | input | WIN_W | Window length in system-clock cycles |
| ring_taps | input | N_STAGES | Outputs of the ring stages (asynchronous) |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle result strobe |
| conv_code | output | RES_W | Result code: CNT_W + clog2(2·N_STAGES) bits |
| conv_phase_err | output | 1 | A snapshot was not a legal ring pattern |

## Verification
The start snapshot is taken at the accepting edge from tap values two edges older. The end snapshot comes W edges later. conv_done and a new code appear at edge W+1 after acceptance, so the first negative edge with conv_done high is the (W+2)-th negative edge after start was driven. The bench model shifts its own record of ring position and edge count through a two-deep history. It updates its expected busy, done, code and error flag at every rising edge, and compares them with the outputs at every falling edge. Directed cases count negative edges from the launch to check the W+2 latency, including cases with a start or a window change while busy. Ring updates fall on odd picosecond times, so no ring change coincides with a system-clock edge.

// File: rtl/ringconv_pkg.sv
// Shared types for the ring oscillator edge counter.
package ringconv_pkg;

    // Conversion sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } conv_state_e;

endpackage

// File: rtl/ring_cycle_counter.sv
// Counts rising edges of one ring tap in the oscillator's own domain.
// The count is published in Gray code, so only one bit changes per edge.
// Assumes the ring runs while rst_n is low, so the reset takes effect.
module ring_cycle_counter #(
    parameter int CNT_W = 20
) (
    input  logic             ring_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_gray
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_next;

    // next binary count
    assign bin_next = bin_q + CNT_W'(1);

    // count tap edges and register the Gray form of the new count
    always_ff @(posedge ring_clk) begin
        if (!rst_n) begin
            bin_q    <= '0;
            cnt_gray <= '0;
        end else begin
            bin_q    <= bin_next;
            cnt_gray <= bin_next ^ (bin_next >> 1);
        end
    end

    // R3: the count crossing to the system clock moves by one bit at a time
    // R3
    gray_step_chk: assert property (@(posedge ring_clk) disable iff (!rst_n)
        $countones(cnt_gray ^ $past(cnt_gray)) <= 1);

endmodule

// File: rtl/sync_chain.sv
// Flip-flop synchronizer chain for a bus, STAGES deep.
// Assumes each bus changes by at most one bit between samples
// (Gray count, ring taps), so a sampled word is old or new, never mixed.
module sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first sampling flop
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                // further resolution flops
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ring_phase_decoder.sv
// Maps a snapshot of all taps of an odd-length inverter ring to a
// position 0 .. 2*N_STAGES-1 inside one period. Position 0 is the state
// just after tap 0 rises. Any other pattern clears phase_ok.
// Assumes N_STAGES is odd.
module ring_phase_decoder #(
    parameter  int N_STAGES = 5,
    localparam int PH_W     = $clog2(2 * N_STAGES),
    localparam int CW       = $clog2(N_STAGES + 1)
) (
    input  logic [N_STAGES-1:0] taps,
    output logic [PH_W-1:0]     phase,
    output logic                phase_ok
);

    logic [N_STAGES-1:0] norm;
    logic [N_STAGES-1:0] exp_rise;
    logic [N_STAGES-1:0] exp_fall;
    logic [CW-1:0]       ones;

    // undo the inversion of every odd stage
    generate
        for (genvar i = 0; i < N_STAGES; i++) begin : g_norm
            if (i % 2 == 1) begin : g_inv
                assign norm[i] = ~taps[i];
            end else begin : g_pass
                assign norm[i] = taps[i];
            end
        end
    endgenerate

    // count the ones and build both legal thermometer shapes
    always_comb begin
        ones = '0;
        for (int i = 0; i < N_STAGES; i++) begin
            ones = ones + CW'(norm[i]);
        end
        for (int i = 0; i < N_STAGES; i++) begin
            exp_rise[i] = (i < int'(ones));
            exp_fall[i] = (i >= N_STAGES - int'(ones));
        end
    end

    // pick the half-period by tap 0 and check the shape
    always_comb begin
        if (norm[0]) begin
            phase    = PH_W'(ones) - PH_W'(1);
            phase_ok = (norm == exp_rise);
        end else begin
            phase    = PH_W'(2 * N_STAGES - 1) - PH_W'(ones);
            phase_ok = (norm == exp_fall);
        end
    end

endmodule

// File: rtl/conv_window_ctrl.sv
// Runs the conversion window in the system clock domain. It latches the
// start snapshot (count, position, legality) when it accepts a start and
// the end snapshot W cycles later. It forms the code one cycle after that.
// Assumes its snapshot inputs are already synchronized.
module conv_window_ctrl
    import ringconv_pkg::*;
#(
    parameter  int N_STAGES = 5,
    parameter  int CNT_W    = 20,
    parameter  int WIN_W    = 24,
    localparam int PH_W     = $clog2(2 * N_STAGES),
    localparam int RES_W    = CNT_W + PH_W,
    localparam int TWO_N    = 2 * N_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIN_W-1:0] window,
    input  logic [CNT_W-1:0] cnt_now,
    input  logic [PH_W-1:0]  ph_now,
    input  logic             ph_ok_now,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] code,
    output logic             phase_err
);

    conv_state_e      state_q;
    logic [WIN_W-1:0] timer_q;
    logic [CNT_W-1:0] s_cnt_q, e_cnt_q;
    logic [PH_W-1:0]  s_ph_q, e_ph_q;
    logic             s_ok_q, e_ok_q;
    logic [CNT_W-1:0] cnt_span;
    logic [RES_W-1:0] code_next;

    // combine the whole-cycle span with the fine position difference
    always_comb begin
        cnt_span  = e_cnt_q - s_cnt_q;
        code_next = RES_W'(cnt_span) * RES_W'(TWO_N)
                  + RES_W'(e_ph_q) - RES_W'(s_ph_q);
    end

    // sequencer: accept, time the window, take both snapshots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            s_cnt_q <= '0;
            e_cnt_q <= '0;
            s_ph_q  <= '0;
            e_ph_q  <= '0;
            s_ok_q  <= 1'b0;
            e_ok_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start && (window != '0)) begin
                        state_q <= ST_RUN;
                        timer_q <= window;
                        s_cnt_q <= cnt_now;
                        s_ph_q  <= ph_now;
                        s_ok_q  <= ph_ok_now;
                    end
                end
                ST_RUN: begin
                    if (timer_q == WIN_W'(1)) begin
                        state_q <= ST_FIN;
                        e_cnt_q <= cnt_now;
                        e_ph_q  <= ph_now;
                        e_ok_q  <= ph_ok_now;
                    end else begin
                        timer_q <= timer_q - WIN_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // publish the result and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            code      <= '0;
            phase_err <= 1'b0;
        end else begin
            done <= (state_q == ST_FIN);
            if (state_q == ST_FIN) begin
                code      <= code_next;
                phase_err <= !(s_ok_q && e_ok_q);
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(code) && $stable(phase_err)));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (timer_q != '0));

    // R6
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && timer_q != WIN_W'(1)) |=> (state_q == ST_RUN));

    // R7
    zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && window == '0) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ring_phase_counter.sv
// Top of the ring oscillator edge counter. It counts whole ring periods
// on tap 0, synchronizes the Gray count and the full tap vector into the
// system clock, decodes the tap vector to a position, and runs the window.
// Assumes an odd N_STAGES and a window shorter than 2^CNT_W ring periods.
module ring_phase_counter #(
    parameter  int N_STAGES    = 5,
    parameter  int CNT_W       = 20,
    parameter  int WIN_W       = 24,
    parameter  int SYNC_STAGES = 2,
    localparam int PH_W        = $clog2(2 * N_STAGES),
    localparam int RES_W       = CNT_W + PH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start,
    input  logic [WIN_W-1:0]    conv_window,
    input  logic [N_STAGES-1:0] ring_taps,
    output logic                conv_busy,
    output logic                conv_done,
    output logic [RES_W-1:0]    conv_code,
    output logic                conv_phase_err
);

    logic                ring_clk;
    logic [CNT_W-1:0]    gray_ring;
    logic [CNT_W-1:0]    gray_sys;
    logic [CNT_W-1:0]    cnt_sys;
    logic [N_STAGES-1:0] taps_sys;
    logic [PH_W-1:0]     ph_sys;
    logic                ph_ok_sys;

    assign ring_clk = ring_taps[0];

    ring_cycle_counter #(.CNT_W(CNT_W)) u_cycles (
        .ring_clk (ring_clk),
        .rst_n    (rst_n),
        .cnt_gray (gray_ring)
    );

    sync_chain #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gray_ring),
        .q     (gray_sys)
    );

    sync_chain #(.W(N_STAGES), .STAGES(SYNC_STAGES)) u_tap_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ring_taps),
        .q     (taps_sys)
    );

    // Gray to binary conversion of the synchronized count
    always_comb begin
        cnt_sys[CNT_W-1] = gray_sys[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            cnt_sys[i] = cnt_sys[i+1] ^ gray_sys[i];
        end
    end

    ring_phase_decoder #(.N_STAGES(N_STAGES)) u_decode (
        .taps     (taps_sys),
        .phase    (ph_sys),
        .phase_ok (ph_ok_sys)
    );

    conv_window_ctrl #(
        .N_STAGES (N_STAGES),
        .CNT_W    (CNT_W),
        .WIN_W    (WIN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (conv_start),
        .window    (conv_window),
        .cnt_now   (cnt_sys),
        .ph_now    (ph_sys),
        .ph_ok_now (ph_ok_sys),
        .busy      (conv_busy),
        .done      (conv_done),
        .code      (conv_code),
        .phase_err (conv_phase_err)
    );

endmodule

// File: tb/ring_phase_counter_bench.sv
`timescale 1ns/1ps
module ring_phase_counter_bench;

    localparam int N     = 5;
    localparam int CW    = 8;
    localparam int WW    = 24;
    localparam int TWO_N = 2 * N;
    localparam int RW    = CW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [WW-1:0] win = '0;
    logic [N-1:0]  taps;
    logic          busy, done, err;
    logic [RW-1:0] code;

    always #2 clk = ~clk;

    ring_phase_counter #(.N_STAGES(N), .CNT_W(CW), .WIN_W(WW)) u_ring_phase_counter (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_start     (start),
        .conv_window    (win),
        .ring_taps      (taps),
        .conv_busy      (busy),
        .conv_done      (done),
        .conv_code      (code),
        .conv_phase_err (err)
    );

    int total = 0;
    int bad   = 0;
    bit cmp_on = 0;
    bit finished = 0;

    task automatic check(string tag, longint act, longint exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural ring ----------------
    int  phi = 2 * N - 1;
    int  rcnt = 0;
    bit  freeze = 0;
    bit  badpat = 0;
    real stage_ns = 0.312;

    function automatic logic [N-1:0] enc(int p);
        logic [N-1:0] t;
        for (int i = 0; i < N; i++) begin
            bit u;
            u = (p < N) ? (i <= p) : (i > p - N);
            t[i] = u ^ (i % 2 == 1);
        end
        return t;
    endfunction

    task automatic drive();
        logic [N-1:0] v;
        v = badpat ? 5'b01111 : enc(phi);
        if (!taps[0] && v[0]) rcnt++;
        taps = v;
    endtask

    initial begin
        taps = enc(phi);
        #0.001;
        forever begin
            #(stage_ns);
            if (!freeze) begin
                phi = (phi + 1) % TWO_N;
                drive();
            end
        end
    end

    // ---------------- reference model ----------------
    int     h1p = 0, h1c = 0, h2p = 0, h2c = 0;
    bit     h1b = 0, h2b = 0;
    bit     m_busy = 0, m_done = 0, m_err = 0, m_fin = 0, m_wrap = 0;
    int     m_left = 0;
    longint m_code = 0;
    int     sp = 0, sc = 0, ep = 0, ec = 0;
    bit     sb = 0, eb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_fin = 0; m_code = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_fin) begin
                longint span;
                m_fin  = 0;
                m_busy = 0;
                m_done = 1;
                m_err  = sb | eb;
                span   = longint'((ec - sc) & ((1 << CW) - 1));
                m_wrap = (ec & ((1 << CW) - 1)) < (sc & ((1 << CW) - 1));
                m_code = (span * TWO_N + ep - sp) & ((1 << RW) - 1);
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    ep = h2p; ec = h2c; eb = h2b;
                    m_fin = 1;
                end
            end else if (start && win != '0) begin
                m_busy = 1;
                m_left = int'(win);
                sp = h2p; sc = h2c; sb = h2b;
            end
        end
        h2p = h1p; h2c = h1c; h2b = h1b;
        h1p = phi; h1c = rcnt; h1b = badpat;
    end

    // compare outputs with the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check("R2", busy, m_busy, "busy");
            check("R10", done, m_done, "done");
            if (!m_err) check("R3", code, m_code, "code");
            check("R8", err, m_err, "phase_err");
        end
    end

    // ---------------- directed tasks ----------------
    task automatic launch(int w);
        start = 1'b1;
        win   = WW'(w);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int k);
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run(int w, string tag);
        int k;
        launch(w);
        k = 1;
        wait_done(k);
        check(tag, k, w + 2, "done latency");
    endtask

    initial begin
        #600000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=no_done expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        logic [RW-1:0] held;
        @(negedge clk);
        cmp_on = 1;
        repeat (4) @(negedge clk);
        // R1: reset values
        check("R1", busy, 0, "busy in reset");
        check("R1", done, 0, "done in reset");
        check("R1", code, 0, "code in reset");
        check("R1", err, 0, "phase_err in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", code, 0, "code after reset");

        // R2 / R3: several window lengths
        run(1, "R2");
        run(2, "R2");
        run(7, "R3");
        run(50, "R3");
        stage_ns = 0.520;
        repeat (5) @(negedge clk);
        run(100, "R3");
        stage_ns = 0.312;
        repeat (3) @(negedge clk);

        // R4: every start position with a frozen ring
        for (int a = 0; a < TWO_N; a++) begin
            int off;
            off = (a % 3) + 1;
            freeze = 1;
            phi = a;
            drive();
            repeat (3) @(negedge clk);
            launch(4);
            phi = (a + off) % TWO_N;
            drive();
            k = 1;
            wait_done(k);
            check("R4", code, off, "position step");
            check("R4", err, 0, "legal pattern");
            freeze = 0;
            repeat (2) @(negedge clk);
        end

        // R6: start while busy is ignored
        launch(40);
        k = 1;
        repeat (9) begin @(negedge clk); k++; end
        start = 1'b1; win = WW'(3);
        @(negedge clk); k++;
        start = 1'b0;
        check("R6", busy, 1, "busy after second start");
        wait_done(k);
        check("R6", k, 42, "done latency with extra start");

        // R11: window change during a conversion
        repeat (2) @(negedge clk);
        launch(30);
        k = 1;
        repeat (4) begin @(negedge clk); k++; end
        win = WW'(3);
        wait_done(k);
        check("R11", k, 32, "done latency after window change");

        // R9: results hold
        @(negedge clk);
        held = code;
        repeat (25) @(negedge clk);
        check("R9", code, held, "code held");
        check("R9", done, 0, "no strobe while idle");

        // R7: zero window ignored
        start = 1'b1; win = '0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R7", busy, 0, "busy after zero window");
            check("R7", done, 0, "done after zero window");
            check("R7", code, held, "code after zero window");
            @(negedge clk);
        end

        // R8: illegal pattern at the start snapshot
        freeze = 1; badpat = 1; drive();
        repeat (3) @(negedge clk);
        launch(3);
        badpat = 0; drive();
        k = 1;
        wait_done(k);
        check("R8", err, 1, "bad start pattern");
        freeze = 0;
        repeat (2) @(negedge clk);
        run(5, "R8");
        check("R8", err, 0, "legal patterns clear flag");

        // R8: illegal pattern at the end snapshot
        launch(6);
        repeat (2) @(negedge clk);
        freeze = 1; badpat = 1; drive();
        k = 3;
        wait_done(k);
        check("R8", err, 1, "bad end pattern");
        badpat = 0; drive(); freeze = 0;
        repeat (2) @(negedge clk);

        // R5: long windows that span a coarse counter wrap
        for (int j = 0; j < 6; j++) begin
            repeat (7 * j + 1) @(negedge clk);
            run(150, "R5");
            if (m_wrap) check("R5", code, m_code, "code across counter wrap");
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule